// File: doc/BRIEF.md
# Dual-Channel Result Readout Port

This block holds the latest results of a two-channel sampling converter and puts one of them on a 16-bit parallel host bus. An active-low chip-select and an active-low read-enable open the bus. A channel-select input picks which stored result is shown. A byte-order input swaps the two byte lanes, so a host with an 8-bit bus can read both halves of a result through one lane by wiring byte-order to an address line.

The physical tri-state pins are modelled as a data word plus one output-enable per byte lane. The host-side inputs are registered, so any change on them shows on the bus one clock later. The converter sequencer lies outside this block. It sends a completion strobe with each channel's result, and the two channels are stored independently. Channel A can therefore be read as soon as its strobe arrives, even while channel B is still converting. To read continuously without strobes, the host ties chip-select and read-enable low; the bus then tracks every stored update.

Top module: `readout_port`

## Requirements
- R1: While `rst` is high, both `bus_oe` bits are 0 at once, without waiting for a clock. After reset is released, both stored results read as 16'h0000 until they are loaded.
- R2: Both `bus_oe` bits become 1 one clock after `cs_n` and `rd_n` are both sampled low. Both bits become 0 one clock after either input is sampled high.
- R3: One clock after `chan_a_sel` is sampled at 1, the bus carries channel A's stored result. One clock after it is sampled at 0, the bus carries channel B's stored result.
- R4: With `byte_swap` sampled at 0, result bits 7:0 appear on `bus_data[7:0]` and bits 15:8 on `bus_data[15:8]`. With `byte_swap` sampled at 1, bits 7:0 appear on `bus_data[15:8]` and bits 15:8 on `bus_data[7:0]`.
- R5: A clock edge with `a_done` high stores `a_result` as channel A's result and leaves channel B's result unchanged. The new A value is on the bus one further clock later.
- R6: A clock edge with `b_done` high stores `b_result` as channel B's result and leaves channel A's result unchanged.
- R7: When `a_done` and `b_done` are high on the same edge, both results are stored.
- R8: While `cs_n` and `rd_n` are held low, the bus follows stored-result updates with no read strobe. A result stored on edge k is on the bus after edge k+1.
- R9: When both `bus_oe` bits are 0, `bus_data` is 16'h0000.
- R10: A stored result changes only on an edge where its own completion strobe is high. Reads never alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| chan_a_sel | input | 1 | 1 selects channel A, 0 selects channel B |
| byte_swap | input | 1 | 1 exchanges the two byte lanes |
| a_done | input | 1 | Channel A completion strobe |
| a_result | input | 16 | Channel A conversion result |
| b_done | input | 1 | Channel B completion strobe |
| b_result | input | 16 | Channel B conversion result |
| bus_data | output | 16 | Bus data word |
| bus_oe | output | 2 | Per-lane output enable (bit 0 drives lane 7:0, bit 1 drives lane 15:8) |

## Verification
The hardest case to reach from the ports is a bus that is already driven and holds an old channel-A value when a fresh A result arrives while B has not finished. To reach it, the stimulus holds chip-select and read-enable low with channel A selected and pulses only `a_done`. It then samples on both sides of the one-clock output register, to confirm the old value is still present one edge after the strobe and the new value one edge later. It then flips the select to confirm that channel B still holds its earlier value. A second case asserts reset mid-read and checks that the enables drop before the next clock edge.

// File: rtl/readout_pkg.sv
package readout_pkg;
  typedef enum logic {
    CH_B = 1'b0,
    CH_A = 1'b1
  } chan_e;
endpackage

// File: rtl/result_store.sv
module result_store #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        done,
  input  logic [NCH-1:0][W-1:0] din,
  output logic [NCH-1:0][W-1:0] res
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or posedge rst) begin
      if (rst)          res[c] <= '0;
      else if (done[c]) res[c] <= din[c];
    end

    // R5/R6: a strobed channel takes its input
    p_load_r5: assert property (@(posedge clk) disable iff (rst)
      done[c] |=> res[c] == $past(din[c]));
    // R10: without its strobe a channel keeps its value
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !done[c] |=> $stable(res[c]));
  end
endmodule

// File: rtl/lane_mux.sv
module lane_mux
  import readout_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] res_a,
  input  logic [W-1:0] res_b,
  input  chan_e        chan,
  input  logic         swap,
  output logic [W-1:0] word
);
  localparam int LANES = W / 8;

  function automatic logic [W-1:0] reverse_lanes(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*8 +: 8] = v[(LANES-1-i)*8 +: 8];
    return r;
  endfunction

  logic [W-1:0] picked;

  always_comb begin
    picked = (chan == CH_A) ? res_a : res_b;
    word   = swap ? reverse_lanes(picked) : picked;
  end
endmodule

// File: rtl/bus_drive.sv
module bus_drive #(
  parameter int W = 16,
  localparam int LANES = W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [W-1:0]     word,
  output logic [W-1:0]     bus_data,
  output logic [LANES-1:0] bus_oe
);
  logic read_open;
  assign read_open = !cs_n && !rd_n;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bus_oe   <= '0;
      bus_data <= '0;
    end else begin
      bus_oe   <= {LANES{read_open}};
      bus_data <= read_open ? word : '0;
    end
  end

  // R1: enables stay low whenever reset is held
  p_idle_in_reset_r1: assert property (@(posedge clk)
    rst |-> bus_oe == '0);
  // R2: selects low open every lane next cycle
  p_open_r2: assert property (@(posedge clk) disable iff (rst)
    read_open |=> bus_oe == {LANES{1'b1}});
  // R2: either select high closes every lane next cycle
  p_close_r2: assert property (@(posedge clk) disable iff (rst)
    !read_open |=> bus_oe == '0);
  // R9: an undriven bus carries zero
  p_quiet_data_r9: assert property (@(posedge clk) disable iff (rst)
    bus_oe == '0 |-> bus_data == '0);
endmodule

// File: rtl/readout_port.sv
module readout_port
  import readout_pkg::*;
#(
  parameter int W = 16,
  localparam int LANES = W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             chan_a_sel,
  input  logic             byte_swap,
  input  logic             a_done,
  input  logic [W-1:0]     a_result,
  input  logic             b_done,
  input  logic [W-1:0]     b_result,
  output logic [W-1:0]     bus_data,
  output logic [LANES-1:0] bus_oe
);
  logic [1:0][W-1:0] res;
  logic [W-1:0]      word;
  chan_e             chan;

  assign chan = chan_e'(chan_a_sel);

  result_store #(.W(W), .NCH(2)) u_store (
    .clk  (clk),
    .rst  (rst),
    .done ({b_done, a_done}),
    .din  ({b_result, a_result}),
    .res  (res)
  );

  lane_mux #(.W(W)) u_mux (
    .res_a (res[0]),
    .res_b (res[1]),
    .chan  (chan),
    .swap  (byte_swap),
    .word  (word)
  );

  bus_drive #(.W(W)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .word     (word),
    .bus_data (bus_data),
    .bus_oe   (bus_oe)
  );
endmodule

// File: tb/readout_port_test.sv
module readout_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, chan_a_sel = 1'b0, byte_swap = 1'b0;
  logic        a_done = 1'b0, b_done = 1'b0;
  logic [15:0] a_result = '0, b_result = '0;
  logic [15:0] bus_data;
  logic [1:0]  bus_oe;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  readout_port uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n),
    .chan_a_sel(chan_a_sel), .byte_swap(byte_swap),
    .a_done(a_done), .a_result(a_result),
    .b_done(b_done), .b_result(b_result),
    .bus_data(bus_data), .bus_oe(bus_oe)
  );

  // {cs_n, rd_n, chan_a_sel, byte_swap, exp_oe[1:0], exp_data[15:0]}
  localparam logic [21:0] VEC [8] = '{
    {4'b0010, 2'b11, 16'hC35A},
    {4'b0011, 2'b11, 16'h5AC3},
    {4'b0000, 2'b11, 16'h0FF1},
    {4'b0001, 2'b11, 16'hF10F},
    {4'b1010, 2'b00, 16'h0000},
    {4'b0100, 2'b00, 16'h0000},
    {4'b1111, 2'b00, 16'h0000},
    {4'b0010, 2'b11, 16'hC35A}
  };

  task automatic check(input string req, input logic [1:0] eoe, input logic [15:0] edata);
    n_chk++;
    if (bus_oe !== eoe || bus_data !== edata) begin
      n_bad++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", req, bus_oe, bus_data, eoe, edata);
    end
  endtask

  task automatic ctrl(input logic c, input logic r, input logic s, input logic w);
    cs_n = c; rd_n = r; chan_a_sel = s; byte_swap = w;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    #2 rst = 1'b1;
    ctrl(0, 0, 1, 0);
    @(negedge clk);
    check("R1 enables low in reset", 2'b00, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cleared A result", 2'b11, 16'h0000);
    chan_a_sel = 0;
    @(negedge clk);
    check("R1 cleared B result", 2'b11, 16'h0000);

    // R7: both strobes on one edge
    a_result = 16'hC35A; b_result = 16'h0FF1; a_done = 1; b_done = 1;
    @(negedge clk);
    a_done = 0; b_done = 0;
    @(negedge clk);

    // R2 R3 R4 R9 vector walk
    for (int i = 0; i < 8; i++) begin
      ctrl(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18]);
      @(negedge clk);
      check($sformatf("R2/R3/R4/R9/R7 vector %0d", i), VEC[i][17:16], VEC[i][15:0]);
    end

    // R5 R8: continuous read, A updates while B pending
    ctrl(0, 0, 1, 0);
    @(negedge clk);
    a_result = 16'h7E81; a_done = 1;
    @(negedge clk);
    a_done = 0;
    check("R8 old A one edge after strobe", 2'b11, 16'hC35A);
    @(negedge clk);
    check("R5 new A visible", 2'b11, 16'h7E81);
    chan_a_sel = 0;
    @(negedge clk);
    check("R5 B untouched by A strobe", 2'b11, 16'h0FF1);

    // R6
    b_result = 16'h2468; b_done = 1;
    @(negedge clk);
    b_done = 0;
    @(negedge clk);
    check("R6 new B visible", 2'b11, 16'h2468);
    chan_a_sel = 1;
    @(negedge clk);
    check("R6 A untouched by B strobe", 2'b11, 16'h7E81);

    // R10: reads with changing inputs but no strobe
    a_result = 16'hFFFF; b_result = 16'hFFFF;
    byte_swap = 1;
    repeat (3) @(negedge clk);
    check("R10 A held, swapped", 2'b11, 16'h817E);

    // R1: reset mid-read acts before any clock
    byte_swap = 0;
    #2 rst = 1'b1;
    #1 check("R1 async disable", 2'b00, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 A cleared by reset", 2'b11, 16'h0000);
    finish_run();
  end
endmodule